// File: doc/BRIEF.md
# Interrupt Source Aggregator

This block gathers up to thirty-two interrupt lines from peripherals into one status word, masks them with a per-line enable word and raises a single request toward the processor. Each line is brought into the bus clock domain through a chain of synchroniser flops before any level or edge decision is made. Software sees the status, enable, polarity and trigger-mode words through a simple register port. A vector word gives the index of the pending enabled line with the lowest number, and a flag in the same word shows when nothing is pending.

The lines fall into three index ranges. The low range is hardwired as active-high and level-sensitive. The middle range is reserved and is inert. The top range has a polarity bit and a trigger-mode bit for each line, so each of those lines can be active-high or active-low, and level-sensitive or edge-sensitive. Edge-sensitive status bits hold their value until software writes a 1 to them. The range limits, the line count and the synchroniser depth are parameters.

Top module: `irqc_top`

## Requirements
- R1: After reset the status and enable words read 0, the trigger word reads 0, the polarity word reads 1 for every implemented line (0–18 and 25–31), `irq_o` is 0 and `vec_none_o` is 1.
- R2: Lines 0–18 are active-high and level-sensitive. Their status bit follows the input. Writes to their polarity or trigger bits have no effect, and those bits read back as 1 and 0.
- R3: Lines 19–24 never set a status bit. They read 0 in every word, and writes to them have no effect.
- R4: A line in 25–31 with trigger bit 0 is level-sensitive. Its status bit is input XNOR polarity, where polarity 1 means active-high and 0 means active-low.
- R5: A line in 25–31 with trigger bit 1 sets its status bit on a change of the input toward its active level. The bit stays set until a 1 is written to it at the status offset. Writing 0 does nothing, and writing 1 to a level-sensitive bit does nothing.
- R6: `irq_o` is 1 exactly when some status bit and its enable bit are both 1.
- R7: The vector word holds the lowest-numbered pending enabled line in bits 4:0 and 0 in bit 31 when such a line exists. When no line is pending and enabled, it reads 0x80000000. `vec_o` and `vec_none_o` carry the same values.
- R8: A change on an input line reaches the status word on the third rising clock edge after it is applied: two synchroniser flops, then the status flop.
- R9: The register offsets on `addr_i` are: 0 status, 1 enable, 2 polarity, 3 trigger (1 = edge), 4 vector. Any other offset reads 0. `rdata_o` is combinational from `addr_i`, and a write takes effect at the clock edge where `wr_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt lines, asynchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | 5 | Lowest pending enabled line |
| vec_none_o | output | 1 | No pending enabled line |

## Verification
The hardest case to reach from the ports is an edge-sensitive status bit that is still set after its input has gone back to the inactive level. Only that bit tells the sticky storage apart from level tracking. The bench drives a one-cycle pulse through the synchroniser, waits until the input has settled inactive, and then shows that a write of 0 leaves the bit set and a write of 1 clears it. It also writes 1 to a level-sensitive bit whose input is high and shows that the bit stays set. Separately, a walking-one sweep over all thirty-two lines and a set of computed enable and source patterns check the priority vector against a lowest-set-bit search done in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [1:0] {
      KIND_FIXED = 2'd0,
      KIND_RSVD  = 2'd1,
      KIND_PROG  = 2'd2
   } src_kind_e;

   localparam int OFS_STAT = 0;
   localparam int OFS_EN   = 1;
   localparam int OFS_POL  = 2;
   localparam int OFS_TRG  = 3;
   localparam int OFS_VEC  = 4;

   function automatic src_kind_e kind_of(input int idx, input int fixed_last,
                                         input int prog_first);
      if (idx <= fixed_last)      return KIND_FIXED;
      else if (idx < prog_first)  return KIND_RSVD;
      else                        return KIND_PROG;
   endfunction

   function automatic logic [63:0] span_mask(input int lo, input int hi);
      logic [63:0] m;
      m = '0;
      for (int b = 0; b < 64; b++)
         if (b >= lo && b <= hi) m[b] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
   import irqc_pkg::*;
#(
   parameter src_kind_e KIND = KIND_FIXED
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic pol_i,
   input  logic edge_i,
   input  logic clr_i,
   output logic stat_o
);
   if (KIND == KIND_RSVD) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^{clk, rst_n, line_i, pol_i, edge_i, clr_i};
      assign stat_o = 1'b0;
   end else if (KIND == KIND_FIXED) begin : g_fixed
      logic stat_q;
      logic unused_fixed;
      assign unused_fixed = ^{pol_i, edge_i, clr_i};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q <= 1'b0;
         else        stat_q <= line_i;
      end
      assign stat_o = stat_q;

      a_r2_fixed_level: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i && line_i |=> stat_o);
   end else begin : g_prog
      logic act, act_q, stat_q;
      assign act = line_i ~^ pol_i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q  <= 1'b0;
            stat_q <= 1'b0;
         end else begin
            act_q <= act;
            if (edge_i) stat_q <= (stat_q & ~clr_i) | (act & ~act_q);
            else        stat_q <= act;
         end
      end
      assign stat_o = stat_q;

      a_r5_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
         edge_i && act && !act_q |=> stat_o);
      a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         edge_i && stat_o && !clr_i |=> stat_o);
      a_r4_level_track: assert property (@(posedge clk) disable iff (!rst_n)
         !edge_i |=> stat_o == $past(act));
   end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int N  = 32,
   localparam int VW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   output logic [VW-1:0] idx_o,
   output logic          found_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            found_o = 1'b1;
            idx_o   = i[VW-1:0];
         end
      end
   end

   a_r7_vec_pending: assert property (@(req_i) found_o |-> req_i[idx_o]);
   a_r7_vec_lowest:  assert property (@(req_i)
      found_o |-> ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int FIXED_LAST  = 18,
   parameter int PROG_FIRST  = 25,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 3,
   localparam int VEC_W      = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              vec_none_o
);
   localparam logic [63:0] FIXED_M64 = span_mask(0, FIXED_LAST);
   localparam logic [63:0] PROG_M64  = span_mask(PROG_FIRST, NUM_SRC - 1);
   localparam logic [NUM_SRC-1:0] FIXED_MASK = FIXED_M64[NUM_SRC-1:0];
   localparam logic [NUM_SRC-1:0] PROG_MASK  = PROG_M64[NUM_SRC-1:0];
   localparam logic [NUM_SRC-1:0] IMPL_MASK  = FIXED_MASK | PROG_MASK;

   if (NUM_SRC < 2 || NUM_SRC > 64) begin : g_bad_n
      $error("NUM_SRC out of range");
   end
   if (FIXED_LAST >= PROG_FIRST || PROG_FIRST >= NUM_SRC) begin : g_bad_split
      $error("source ranges overlap or exceed NUM_SRC");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W < NUM_SRC || DATA_W <= VEC_W) begin : g_bad_data
      $error("DATA_W too narrow");
   end
   if ((1 << ADDR_W) <= OFS_VEC) begin : g_bad_addr
      $error("ADDR_W too narrow");
   end

   logic [NUM_SRC-1:0] line_s, stat, en_q, pol_q, trg_q, clr;
   logic               found;

   irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(line_s));

   wire wr_stat = wr_en_i && (int'(addr_i) == OFS_STAT);
   assign clr = wr_stat ? wdata_i[NUM_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pol_q <= PROG_MASK;
         trg_q <= '0;
      end else if (wr_en_i) begin
         case (int'(addr_i))
            OFS_EN:  en_q  <= wdata_i[NUM_SRC-1:0] & IMPL_MASK;
            OFS_POL: pol_q <= wdata_i[NUM_SRC-1:0] & PROG_MASK;
            OFS_TRG: trg_q <= wdata_i[NUM_SRC-1:0] & PROG_MASK;
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
      irqc_src_cell #(.KIND(kind_of(g, FIXED_LAST, PROG_FIRST))) u_cell (
         .clk(clk), .rst_n(rst_n), .line_i(line_s[g]), .pol_i(pol_q[g]),
         .edge_i(trg_q[g]), .clr_i(clr[g]), .stat_o(stat[g]));
   end

   irqc_prio #(.N(NUM_SRC)) u_prio (
      .req_i(stat & en_q), .idx_o(vec_o), .found_o(found));

   assign vec_none_o = ~found;
   assign irq_o      = found;

   always_comb begin
      rdata_o = '0;
      case (int'(addr_i))
         OFS_STAT: rdata_o[NUM_SRC-1:0] = stat;
         OFS_EN:   rdata_o[NUM_SRC-1:0] = en_q;
         OFS_POL:  rdata_o[NUM_SRC-1:0] = pol_q | FIXED_MASK;
         OFS_TRG:  rdata_o[NUM_SRC-1:0] = trg_q;
         OFS_VEC: begin
            rdata_o[VEC_W-1:0]  = found ? vec_o : '0;
            rdata_o[DATA_W-1]   = ~found;
         end
         default: ;
      endcase
   end

   a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (en_q[vec_o] && stat[vec_o]));
   a_r6_idle_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & en_q) == '0) |-> !irq_o && vec_none_o);
   a_r3_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat | en_q | trg_q) & ~IMPL_MASK) == '0);
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] IMPL = 32'hFE07FFFF;
   localparam logic [31:0] FIX  = 32'h0007FFFF;
   localparam logic [31:0] PRG  = 32'hFE000000;

   logic        clk = 0, rst_n = 0, wr_en = 0;
   logic [31:0] src = 0, wdata = 0, rdata;
   logic [2:0]  addr = 0;
   logic        irq, vnone;
   logic [4:0]  vec;
   int tests = 0, fails = 0;

   irqc_top dut (.clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
      .vec_o(vec), .vec_none_o(vnone));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_vec(input logic [31:0] p);
      for (int b = 0; b < 32; b++) if (p[b]) return b;
      return 32'h80000000;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, p, e, pend;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd(0, d); check("R1 status", d, 0);
      rd(1, d); check("R1 enable", d, 0);
      rd(2, d); check("R1 polarity", d, IMPL);
      rd(3, d); check("R1 trigger", d, 0);
      rd(4, d); check("R1 vector", d, 32'h80000000);
      check("R1 irq", {vnone, irq}, 2'b10);
      // R9 unused offsets
      for (int a = 5; a < 8; a++) begin rd(a[2:0], d); check("R9 unused offset", d, 0); end
      // R3 R9 enable write masks reserved lines
      wr(1, 32'hFFFFFFFF);
      rd(1, d); check("R3 enable mask", d, IMPL);
      // R2 R3 R4 R6 R7 walking one
      for (int i = 0; i < 32; i++) begin
         src = 32'h1 << i; settle();
         e = IMPL[i] ? (32'h1 << i) : 0;
         rd(0, d); check(IMPL[i] ? "R2/R4 walk status" : "R3 reserved status", d, e);
         rd(4, d); check("R7 walk vector", d, exp_vec(e));
         check("R6 walk irq", {31'b0, irq}, {31'b0, IMPL[i]});
      end
      // R8 latency
      src = 0; settle();
      @(negedge clk); src = 32'h1;
      @(negedge clk); @(negedge clk);
      rd(0, d); check("R8 two edges", d, 0);
      @(negedge clk);
      rd(0, d); check("R8 third edge", d, 1);
      // R2 R4 polarity active-low
      src = 0; wr(2, 0);
      rd(2, d); check("R2 polarity fixed bits", d, FIX);
      settle();
      rd(0, d); check("R4 active-low level", d, PRG);
      src = 32'h50000000; settle();
      rd(0, d); check("R4 active-low partial", d, 32'hAE000000);
      wr(3, 32'hFFFFFFFF); wr(2, 32'hFFFFFFFF); src = 0; settle();
      rd(3, d); check("R2 trigger fixed bits", d, PRG);
      wr(0, 32'hFFFFFFFF);
      rd(0, d); check("R5 clear after mode change", d, 0);
      // R5 edge capture with one-cycle pulse
      @(negedge clk); src = 32'h08000000;
      @(negedge clk); src = 0; settle();
      rd(0, d); check("R5 edge sticky", d, 32'h08000000);
      rd(4, d); check("R7 edge vector", d, 27);
      wr(0, 0);
      rd(0, d); check("R5 write zero", d, 32'h08000000);
      src = 32'h1; settle();
      wr(0, 32'h1);
      rd(0, d); check("R5 level not cleared", d, 32'h08000001);
      wr(0, 32'h08000000);
      rd(0, d); check("R5 edge cleared", d, 32'h1);
      wr(1, 0); check("R6 disabled irq", {31'b0, irq}, 0);
      rd(4, d); check("R7 disabled vector", d, 32'h80000000);
      // R6 R7 priority patterns in level mode
      wr(3, 0);
      for (int k = 0; k < 24; k++) begin
         p = (32'h9E3779B9 * (k + 1)) ^ (32'h1 << k);
         e = ~((32'h00F00F0F << (k % 7)) | (32'h1 << ((k * 5) % 32)));
         if (k % 4 == 0) e = 32'hFFFFFFFF;
         wr(1, e); src = p; settle();
         pend = p & e & IMPL;
         rd(4, d); check("R7 pattern vector", d, exp_vec(pend));
         check("R7 vec port", {26'b0, vnone, vec}, (pend == 0) ? 32'h20 : exp_vec(pend));
         check("R6 pattern irq", {31'b0, irq}, {31'b0, pend != 0});
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule